// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Rate Trim

This block keeps IEEE 1588 time of day in a dedicated timestamp clock domain. A 102-bit timer is split into three fields. Seconds (48 bits) sit on top, nanoseconds (30 bits) sit in the middle, and a 24-bit binary fraction of a nanosecond sits at the bottom. On every clock the timer adds a software-programmed increment. The nanosecond and fraction fields wrap at one second and carry into the seconds field. The increment is held in the block and defaults to 4 ns, which suits a 250 MHz timer clock.

A servo outside the block steers the rate through a 2-bit trim input that is sampled on every cycle. One code gives the normal rate, one adds a nanosecond and one removes a nanosecond. The fourth code has a special action, which the `STEP_ON_HOLD` parameter selects. With the parameter set, the seconds field steps on every cycle. With it clear, the time is snapshotted into a strobe register. Software can also load seconds and nanoseconds directly.

The block presents three outputs. The first is the top 94 timer bits. The second is a one-pulse-per-second square wave taken from the seconds LSB. The third is a flag that is high while the top 70 timer bits equal a programmed comparison value.

Top module: `ptp_tod_counter`

## Requirements
- R1: While reset is asserted and until the first update after reset, the timer reads zero and the snapshot register reads zero. The per-cycle increment resets to 4 ns with a zero fraction.
- R2: `tod_out` carries timer bits 101..8. Seconds are at [93:46], nanoseconds at [45:16] and the top 16 fraction bits at [15:0].
- R3: With `trim_ctrl` = 2'b11 and no load, each clock adds the increment register (nanosecond part and fraction part) to the timer.
- R4: With `trim_ctrl` = 2'b01 the nanosecond part of that cycle's step is one more than programmed. With 2'b10 it is one less, but it never goes below zero. A programmed 0 ns stays 0 ns. The fraction part of the step is not trimmed.
- R5: When nanoseconds plus the step reach 10^9 or more, the nanosecond field takes the excess above 10^9 and seconds increase by one in the same cycle.
- R6: `pps_out` equals the seconds LSB (`tod_out` bit 46), so it toggles once per elapsed second.
- R7: With `STEP_ON_HOLD` = 1 and `trim_ctrl` = 2'b00, each clock clears the nanosecond and fraction fields and adds one to seconds.
- R8: With `STEP_ON_HOLD` = 0, code 2'b00 counts like 2'b11. The snapshot register `snap_time` loads the pre-update timer value only in a cycle where `trim_ctrl` is 2'b00 and it was 2'b11 in the previous cycle. The new value is visible after that edge. Holding 2'b00, or entering 2'b00 from 2'b01 or 2'b10, leaves the register unchanged.
- R9: `cmp_match` is high exactly while timer bits 101..32 equal `cmp_val`. It follows the timer register without an added delay.
- R10: A pulse on `incr_wr` replaces the increment at that edge. That same edge still adds the old increment, and the new one applies from the next edge.
- R11: A pulse on `time_ld` writes seconds and nanoseconds and clears the fraction. It overrides counting, trim and seconds-step in that cycle.
- R12: A carry out of the 24-bit fraction adds one nanosecond in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ts | input | 1 | Timestamp clock |
| rst_ts_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_ld | input | 1 | Load strobe for seconds and nanoseconds |
| time_ld_sec | input | 48 | Seconds value to load |
| time_ld_ns | input | 30 | Nanoseconds value to load, below 10^9 |
| incr_wr | input | 1 | Write strobe for the per-cycle increment |
| incr_ns_in | input | 8 | Increment, whole nanoseconds |
| incr_sub_in | input | 24 | Increment, fraction of a nanosecond |
| trim_ctrl | input | 2 | Rate trim and special-action code |
| cmp_val | input | 70 | Value compared with timer bits 101..32 |
| tod_out | output | 94 | Top 94 timer bits |
| pps_out | output | 1 | Seconds LSB, a 1 PPS square wave |
| cmp_match | output | 1 | High while the top 70 timer bits equal `cmp_val` |
| snap_time | output | 102 | Snapshot register, zero in seconds-step mode |

## Verification
The assertions assume that any nanosecond value loaded through `time_ld` is below 10^9. They also assume the increment never exceeds 255 ns, a limit the port width already enforces. Under these assumptions the nanosecond field always stays in range, and a seconds toggle without a load or a step leaves only a small residue after the wrap.

The stimulus loads only legal nanosecond values. It drives the trim code into each of its four values and into the transitions that lead to 2'b00. It places loads close to 10^9 with increments of both small and large excess. It moves the comparison window through a run of counting cycles.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef enum logic [1:0] {
    TRIM_HOLD = 2'b00,
    TRIM_FAST = 2'b01,
    TRIM_SLOW = 2'b10,
    TRIM_RUN  = 2'b11
  } trim_e;

endpackage

// File: rtl/ptp_tod_step.sv
module ptp_tod_step #(
  parameter int INC_NS_W = 8,
  parameter int SUB_W    = 24
) (
  input  logic [1:0]          ctrl_i,
  input  logic [INC_NS_W-1:0] inc_ns_i,
  input  logic [SUB_W-1:0]    inc_sub_i,
  output logic [INC_NS_W:0]   step_ns_o,
  output logic [SUB_W-1:0]    step_sub_o
);
  import ptp_tod_pkg::*;

  localparam logic [INC_NS_W:0] ONE_NS = {{INC_NS_W{1'b0}}, 1'b1};

  logic [INC_NS_W:0] inc_ext;

  always_comb begin
    inc_ext    = {1'b0, inc_ns_i};
    step_sub_o = inc_sub_i;
    case (trim_e'(ctrl_i))
      TRIM_FAST: step_ns_o = inc_ext + ONE_NS;
      TRIM_SLOW: step_ns_o = (inc_ns_i == '0) ? '0 : inc_ext - ONE_NS;
      default:   step_ns_o = inc_ext;
    endcase
  end

endmodule

// File: rtl/ptp_tod_acc.sv
module ptp_tod_acc #(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30,
  parameter int SUB_W    = 24,
  parameter int INC_NS_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic [SEC_W-1:0]    ld_sec_i,
  input  logic [NS_W-1:0]     ld_ns_i,
  input  logic                jump_i,
  input  logic [INC_NS_W:0]   step_ns_i,
  input  logic [SUB_W-1:0]    step_sub_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [NS_W-1:0]     ns_o,
  output logic [SUB_W-1:0]    sub_o
);
  import ptp_tod_pkg::*;

  localparam int NSX_W = NS_W + 1;
  localparam logic [NS_W:0]    NS_LIM  = NSX_W'(NS_PER_SEC);
  localparam logic [SEC_W-1:0] SEC_ONE = {{(SEC_W-1){1'b0}}, 1'b1};

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [NS_W-1:0]  ns_q, ns_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [SUB_W:0]   sub_sum;
  logic [NS_W:0]    ns_sum, ns_wrap;
  logic             wrap;

  // fraction add, carry into ns, single subtract keeps the excess
  always_comb begin
    sub_sum = {1'b0, sub_q} + {1'b0, step_sub_i};
    ns_sum  = {1'b0, ns_q}
            + {{(NS_W-INC_NS_W){1'b0}}, step_ns_i}
            + {{NS_W{1'b0}}, sub_sum[SUB_W]};
    wrap    = (ns_sum >= NS_LIM);
    ns_wrap = ns_sum - NS_LIM;
  end

  always_comb begin
    sec_d = sec_q;
    ns_d  = ns_q;
    sub_d = sub_q;
    if (ld_i) begin
      sec_d = ld_sec_i;
      ns_d  = ld_ns_i;
      sub_d = '0;
    end else if (jump_i) begin
      sec_d = sec_q + SEC_ONE;
      ns_d  = '0;
      sub_d = '0;
    end else begin
      sub_d = sub_sum[SUB_W-1:0];
      if (wrap) begin
        ns_d  = ns_wrap[NS_W-1:0];
        sec_d = sec_q + SEC_ONE;
      end else begin
        ns_d  = ns_sum[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
      sub_q <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
      sub_q <= sub_d;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;
  assign sub_o = sub_q;

  assert_ns_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, ns_q} < NS_LIM);

  assert_sec_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + SEC_ONE));

  assert_load_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (sec_q == $past(ld_sec_i)) && (ns_q == $past(ld_ns_i)) && (sub_q == '0));

endmodule

// File: rtl/ptp_tod_snap.sv
module ptp_tod_snap #(
  parameter int TOT_W = 102
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ctrl_i,
  input  logic [TOT_W-1:0] time_i,
  output logic [TOT_W-1:0] snap_o
);
  import ptp_tod_pkg::*;

  logic [1:0]       prev_q;
  logic [TOT_W-1:0] snap_q, snap_d;
  logic             fire;

  always_comb begin
    fire   = (trim_e'(prev_q) == TRIM_RUN) && (trim_e'(ctrl_i) == TRIM_HOLD);
    snap_d = fire ? time_i : snap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= TRIM_HOLD;
      snap_q <= '0;
    end else begin
      prev_q <= ctrl_i;
      snap_q <= snap_d;
    end
  end

  assign snap_o = snap_q;

  assert_hold_no_recapture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == TRIM_HOLD && prev_q != TRIM_RUN) |=> $stable(snap_q));

  assert_capture_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == TRIM_HOLD && prev_q == TRIM_RUN) |=> snap_q == $past(time_i));

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int SEC_W        = 48,
  parameter int NS_W         = 30,
  parameter int SUB_W        = 24,
  parameter int INC_NS_W     = 8,
  parameter int OUT_W        = 94,
  parameter int CMP_W        = 70,
  parameter int RST_INC_NS   = 4,
  parameter bit STEP_ON_HOLD = 1'b0
) (
  input  logic                         clk_ts,
  input  logic                         rst_ts_n,
  input  logic                         time_ld,
  input  logic [SEC_W-1:0]             time_ld_sec,
  input  logic [NS_W-1:0]              time_ld_ns,
  input  logic                         incr_wr,
  input  logic [INC_NS_W-1:0]          incr_ns_in,
  input  logic [SUB_W-1:0]             incr_sub_in,
  input  logic [1:0]                   trim_ctrl,
  input  logic [CMP_W-1:0]             cmp_val,
  output logic [OUT_W-1:0]             tod_out,
  output logic                         pps_out,
  output logic                         cmp_match,
  output logic [SEC_W+NS_W+SUB_W-1:0]  snap_time
);
  import ptp_tod_pkg::*;

  localparam int TOT_W = SEC_W + NS_W + SUB_W;
  localparam logic [NS_W-1:0] PPS_WIN = NS_W'(2 ** (INC_NS_W + 1));

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_ts or negedge rst_ts_n) begin
    if (!rst_ts_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // increment register
  logic [INC_NS_W-1:0] inc_ns_q, inc_ns_d;
  logic [SUB_W-1:0]    inc_sub_q, inc_sub_d;

  always_comb begin
    inc_ns_d  = incr_wr ? incr_ns_in  : inc_ns_q;
    inc_sub_d = incr_wr ? incr_sub_in : inc_sub_q;
  end

  always_ff @(posedge clk_ts or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      inc_ns_q  <= INC_NS_W'(RST_INC_NS);
      inc_sub_q <= '0;
    end else begin
      inc_ns_q  <= inc_ns_d;
      inc_sub_q <= inc_sub_d;
    end
  end

  logic [INC_NS_W:0] step_ns;
  logic [SUB_W-1:0]  step_sub;
  logic              jump;
  logic [SEC_W-1:0]  sec;
  logic [NS_W-1:0]   ns;
  logic [SUB_W-1:0]  sub;
  logic [TOT_W-1:0]  timer;

  assign jump = STEP_ON_HOLD && (trim_e'(trim_ctrl) == TRIM_HOLD);

  ptp_tod_step #(.INC_NS_W(INC_NS_W), .SUB_W(SUB_W)) u_step (
    .ctrl_i     (trim_ctrl),
    .inc_ns_i   (inc_ns_q),
    .inc_sub_i  (inc_sub_q),
    .step_ns_o  (step_ns),
    .step_sub_o (step_sub)
  );

  ptp_tod_acc #(.SEC_W(SEC_W), .NS_W(NS_W), .SUB_W(SUB_W), .INC_NS_W(INC_NS_W)) u_acc (
    .clk_i      (clk_ts),
    .rst_ni     (rst_sync_q),
    .ld_i       (time_ld),
    .ld_sec_i   (time_ld_sec),
    .ld_ns_i    (time_ld_ns),
    .jump_i     (jump),
    .step_ns_i  (step_ns),
    .step_sub_i (step_sub),
    .sec_o      (sec),
    .ns_o       (ns),
    .sub_o      (sub)
  );

  assign timer     = {sec, ns, sub};
  assign tod_out   = timer[TOT_W-1 -: OUT_W];
  assign pps_out   = sec[0];
  assign cmp_match = (timer[TOT_W-1 -: CMP_W] == cmp_val);

  generate
    if (STEP_ON_HOLD) begin : g_no_snap
      assign snap_time = '0;
    end else begin : g_snap
      ptp_tod_snap #(.TOT_W(TOT_W)) u_snap (
        .clk_i  (clk_ts),
        .rst_ni (rst_sync_q),
        .ctrl_i (trim_ctrl),
        .time_i (timer),
        .snap_o (snap_time)
      );
    end
  endgenerate

  assert_cmp_flag_R9: assert property (@(posedge clk_ts) disable iff (!rst_sync_q)
    cmp_match |-> tod_out[OUT_W-1 -: CMP_W] == cmp_val);

  assert_pps_wrap_R6: assert property (@(posedge clk_ts) disable iff (!rst_sync_q)
    (!$stable(pps_out) && !$past(time_ld) && !$past(jump)) |-> ns < PPS_WIN);

endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         time_ld;
  logic [47:0]  ld_sec;
  logic [29:0]  ld_ns;
  logic         incr_wr;
  logic [7:0]   incr_ns_in;
  logic [23:0]  incr_sub_in;
  logic [1:0]   trim_ctrl;
  logic [69:0]  cmpv, cmp_next;
  logic [93:0]  tod_out, tod_s;
  logic         pps_out, pps_s, cmp_match, cmp_s;
  logic [101:0] snap_time, snap_s;

  always #(CLK_P/2) clk = ~clk;

  ptp_tod_counter u_dut (
    .clk_ts(clk), .rst_ts_n(rst_n), .time_ld(time_ld), .time_ld_sec(ld_sec),
    .time_ld_ns(ld_ns), .incr_wr(incr_wr), .incr_ns_in(incr_ns_in),
    .incr_sub_in(incr_sub_in), .trim_ctrl(trim_ctrl), .cmp_val(cmpv),
    .tod_out(tod_out), .pps_out(pps_out), .cmp_match(cmp_match), .snap_time(snap_time)
  );

  ptp_tod_counter #(.STEP_ON_HOLD(1'b1)) u_dut_step (
    .clk_ts(clk), .rst_ts_n(rst_n), .time_ld(time_ld), .time_ld_sec(ld_sec),
    .time_ld_ns(ld_ns), .incr_wr(incr_wr), .incr_ns_in(incr_ns_in),
    .incr_sub_in(incr_sub_in), .trim_ctrl(trim_ctrl), .cmp_val(cmpv),
    .tod_out(tod_s), .pps_out(pps_s), .cmp_match(cmp_s), .snap_time(snap_s)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard queues
  logic [93:0]  q_tod[$];
  logic [93:0]  q_tods[$];
  logic         q_cmp[$];
  logic         q_pps[$];
  logic [101:0] q_snap[$];
  string        q_tag[$];

  // reference state
  longint m_sec = 0, m_ns = 0, m_sub = 0;
  longint s_sec = 0, s_ns = 0, s_sub = 0;
  longint inc_ns_m = 4, inc_sub_m = 0;
  logic [1:0]   m_prev = 2'b11;
  logic [101:0] m_snap = '0;

  function automatic logic [101:0] pack(longint sec, longint ns, longint sub);
    logic [63:0] a, b, c;
    a = sec; b = ns; c = sub;
    return {a[47:0], b[29:0], c[23:0]};
  endfunction

  task automatic adv(inout longint sec, inout longint ns, inout longint sub,
                     input bit stepm, input logic [1:0] c);
    longint st, ssum, nsum;
    if (c == 2'b00 && stepm) begin
      sec = sec + 1; ns = 0; sub = 0;
      return;
    end
    st = inc_ns_m;
    if (c == 2'b01) st = st + 1;
    else if (c == 2'b10) st = (st == 0) ? 0 : st - 1;
    ssum = sub + inc_sub_m;
    sub  = ssum & 64'hFFFFFF;
    nsum = ns + st + (ssum >> 24);
    if (nsum >= 1000000000) begin
      nsum = nsum - 1000000000;
      sec  = sec + 1;
    end
    ns = nsum;
  endtask

  task automatic chk(bit ok, string what, logic [101:0] act, logic [101:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(bit l, longint lsec, longint lns, bit w, longint wns,
                       longint wsub, logic [1:0] c, string tag);
    logic [101:0] e;
    @(negedge clk);
    time_ld = l; ld_sec = 48'(lsec); ld_ns = 30'(lns);
    incr_wr = w; incr_ns_in = 8'(wns); incr_sub_in = 24'(wsub);
    trim_ctrl = c; cmpv = cmp_next;
    if (m_prev == 2'b11 && c == 2'b00) m_snap = pack(m_sec, m_ns, m_sub);
    m_prev = c;
    if (l) begin
      m_sec = lsec; m_ns = lns; m_sub = 0;
      s_sec = lsec; s_ns = lns; s_sub = 0;
    end else begin
      adv(m_sec, m_ns, m_sub, 1'b0, c);
      adv(s_sec, s_ns, s_sub, 1'b1, c);
    end
    if (w) begin inc_ns_m = wns; inc_sub_m = wsub; end
    e = pack(m_sec, m_ns, m_sub);
    q_tod.push_back(e[101:8]);
    q_cmp.push_back(e[101:32] == cmpv);
    q_pps.push_back(e[54]);
    q_snap.push_back(m_snap);
    e = pack(s_sec, s_ns, s_sub);
    q_tods.push_back(e[101:8]);
    q_tag.push_back(tag);
  endtask

  task automatic run(int n, logic [1:0] c, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, c, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q_tod.size() > 0) begin
      logic [93:0]  et, es;
      logic         ec, ep;
      logic [101:0] en;
      string        tg;
      et = q_tod.pop_front(); es = q_tods.pop_front(); ec = q_cmp.pop_front();
      ep = q_pps.pop_front(); en = q_snap.pop_front(); tg = q_tag.pop_front();
      chk(tod_out === et, {tg, " R2 tod_out"}, 102'(tod_out), 102'(et));
      chk(pps_out === ep, {tg, " R6 pps_out"}, 102'(pps_out), 102'(ep));
      chk(cmp_match === ec, {tg, " R9 cmp_match"}, 102'(cmp_match), 102'(ec));
      chk(snap_time === en, {tg, " R8 snap_time"}, snap_time, en);
      chk(tod_s === es, {tg, " R7 step-mode tod_out"}, 102'(tod_s), 102'(es));
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; time_ld = 1'b0; ld_sec = '0; ld_ns = '0; incr_wr = 1'b0;
    incr_ns_in = '0; incr_sub_in = '0; trim_ctrl = 2'b11;
    cmpv = '1; cmp_next = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tod_out == '0, "R1 reset tod_out", 102'(tod_out), '0);
    chk(snap_time == '0, "R1 reset snap_time", snap_time, '0);
    chk(cmp_match == 1'b0, "R1 reset cmp_match", 102'(cmp_match), '0);
    chk(tod_s == '0, "R1 reset step tod_out", 102'(tod_s), '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(1, 0, 100, 0, 0, 0, 2'b11, "R11 load");
    run(4, 2'b11, "R1 R3 default increment");
    run(2, 2'b01, "R4 trim fast");
    run(2, 2'b10, "R4 trim slow");
    drive(0, 0, 0, 1, 3, 24'h800000, 2'b11, "R10 write increment");
    run(4, 2'b11, "R12 fraction carry");
    drive(1, 5, 999999990, 0, 0, 0, 2'b11, "R11 load near wrap");
    run(6, 2'b11, "R5 R6 rollover");
    drive(0, 0, 0, 1, 200, 24'h400000, 2'b11, "R10 large increment");
    drive(1, 9, 999999900, 0, 0, 0, 2'b11, "R11 load");
    run(4, 2'b11, "R5 excess carried");
    run(2, 2'b01, "R5 excess with trim fast");
    drive(0, 0, 0, 1, 0, 24'h200000, 2'b11, "R10 zero ns increment");
    run(3, 2'b10, "R4 slow clamps at zero");
    run(2, 2'b01, "R4 fast from zero");
    drive(0, 0, 0, 1, 4, 0, 2'b11, "R10 restore increment");
    cmp_next = {48'd7, 22'd1};
    drive(1, 7, 240, 0, 0, 0, 2'b11, "R9 R11 load before window");
    run(70, 2'b11, "R9 compare window");
    cmp_next = '1;
    run(2, 2'b11, "R8 R3 before hold");
    run(3, 2'b00, "R8 R7 hold from run");
    run(2, 2'b11, "R8 back to run");
    run(1, 2'b01, "R8 R4 fast");
    run(2, 2'b00, "R8 R7 hold from fast");
    run(1, 2'b10, "R8 R4 slow");
    run(1, 2'b00, "R8 hold from slow");
    run(1, 2'b11, "R8 run");
    drive(1, 40, 500, 0, 0, 0, 2'b00, "R11 R8 load during hold");
    run(2, 2'b00, "R7 R8 hold after load");
    run(3, 2'b11, "R3 final run");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule